// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset and an access kind into a 20-bit physical byte address. It holds four 16-bit segment base registers: code, stack, data and extra. For each request it picks the base that belongs to the access kind. It shifts that base left by four bit positions and adds the offset. Because of the shift, each segment is a 64 KB window, and windows whose bases differ by less than 1000h overlap inside a 1 MB space.

A request can carry a segment override. The override replaces the default base for stack and data accesses only. Software-visible sequencing writes the base registers through a simple write port. A write becomes visible to requests issued on the next cycle. The address and its valid flag are registered, so the result appears one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: For each accepted request, physAddr equals (selected segment × 16) + offset, taken to 20 bits. For example, segment 1234h with offset 0011h gives 12351h.
- R2: A carry out of bit 19 is discarded, so addresses wrap at 1 MB. Segment FFFFh with offset 0010h gives 00000h, and with offset FFFFh gives 0FFEFh.
- R3: The reqKind encoding selects the default segment: 0 = code fetch uses the code segment, 1 = stack access uses the stack segment, 2 = data access uses the data segment, 3 = string destination uses the extra segment.
- R4: When ovrValid is 1 and reqKind is 1 or 2, ovrCode picks the segment: 0 = extra, 1 = code, 2 = stack, 3 = data.
- R5: For reqKind 0 and 3, the override inputs are ignored. These accesses always use their default segment.
- R6: When ovrValid is 0, ovrCode has no effect on the address.
- R7: segWrEn with segWrSel (same code as R4: 0 = extra, 1 = code, 2 = stack, 3 = data) loads segWrData into that segment. Requests in the following cycle and later see the new value. A request in the same cycle as the write uses the old value.
- R8: addrValid equals reqValid delayed by exactly one clock.
- R9: physAddr holds its value in cycles that follow a cycle without a request.
- R10: After reset, addrValid is 0, physAddr is 0 and all four segment registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Address request this cycle |
| reqKind | input | 2 | Access kind (R3 encoding) |
| reqOffset | input | 16 | Offset within the segment |
| ovrValid | input | 1 | Segment override present |
| ovrCode | input | 2 | Override segment code |
| segWrEn | input | 1 | Segment register write strobe |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | New segment base value |
| addrValid | output | 1 | Registered address valid |
| physAddr | output | 20 | Registered 20-bit physical address |

## Verification
A segment register write and an address request can fall in the same cycle, including a request that targets the very segment being written. The bench provokes this with a directed cycle that loads the code segment while a code fetch is issued. It then repeats the overlap many times in a pseudo-random stream of writes, overrides and requests. A cycle-level reference model in the bench applies each write only after computing that cycle's expected address. Any mismatch on the registered outputs therefore shows that the design used the new value too early or too late.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int SEG_IDX_W = 2;
  localparam int KIND_W    = 2;

  // Segment register index; the same code serves override and write select.
  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } segIdx_t;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH  = 2'd0,
    KIND_STACK  = 2'd1,
    KIND_DATA   = 2'd2,
    KIND_STRDST = 2'd3
  } accKind_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic    capture;
    logic    segWrite;
    segIdx_t wrIdx;
    segIdx_t rdIdx;
  } dpCtrl_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic                 reqValid,
  input  logic [KIND_W-1:0]    reqKind,
  input  logic                 ovrValid,
  input  logic [SEG_IDX_W-1:0] ovrCode,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrSel,
  output dpCtrl_t              ctrl
);

  accKind_t kind;
  segIdx_t  defaultSeg;
  logic     overridable;

  assign kind = accKind_t'(reqKind);

  always_comb begin
    defaultSeg  = SEG_CODE;
    overridable = 1'b0;
    unique case (kind)
      KIND_FETCH:  begin defaultSeg = SEG_CODE;  overridable = 1'b0; end
      KIND_STACK:  begin defaultSeg = SEG_STACK; overridable = 1'b1; end
      KIND_DATA:   begin defaultSeg = SEG_DATA;  overridable = 1'b1; end
      KIND_STRDST: begin defaultSeg = SEG_EXTRA; overridable = 1'b0; end
      default:     begin defaultSeg = SEG_CODE;  overridable = 1'b0; end
    endcase
  end

  always_comb begin
    ctrl.capture  = reqValid;
    ctrl.segWrite = segWrEn;
    ctrl.wrIdx    = segIdx_t'(segWrSel);
    ctrl.rdIdx    = (overridable && ovrValid) ? segIdx_t'(ovrCode) : defaultSeg;
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtrl_t                   ctrl,
  input  logic [OFF_W-1:0]          offset,
  input  logic [SEG_W-1:0]          wrData,
  output logic                      addrValid,
  output logic [SEG_W+SHIFT-1:0]    physAddr
);

  localparam int ADDR_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]  segBank [NUM_SEG];
  logic [SEG_W-1:0]  baseSel;
  logic [ADDR_W-1:0] baseShifted;
  logic [ADDR_W-1:0] offWide;
  logic [ADDR_W-1:0] sum;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN)
        segBank[g] <= '0;
      else if (ctrl.segWrite && (int'(ctrl.wrIdx) == g))
        segBank[g] <= wrData;
    end
  end

  assign baseSel     = segBank[ctrl.rdIdx];
  assign baseShifted = {baseSel, {SHIFT{1'b0}}};
  assign offWide     = ADDR_W'(offset);
  assign sum         = baseShifted + offWide;  // carry beyond top bit dropped

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
    end else begin
      addrValid <= ctrl.capture;
      if (ctrl.capture)
        physAddr <= sum;
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [1:0]             reqKind,
  input  logic [OFF_W-1:0]       reqOffset,
  input  logic                   ovrValid,
  input  logic [1:0]             ovrCode,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [SEG_W-1:0]       segWrData,
  output logic                   addrValid,
  output logic [SEG_W+SHIFT-1:0] physAddr
);

  localparam int NUM_SEG = 1 << SEG_IDX_W;

  dpCtrl_t ctrl;

  seg_addr_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .ovrValid (ovrValid),
    .ovrCode  (ovrCode),
    .segWrEn  (segWrEn),
    .segWrSel (segWrSel),
    .ctrl     (ctrl)
  );

  seg_addr_dp #(
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W),
    .SHIFT   (SHIFT),
    .NUM_SEG (NUM_SEG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .offset    (reqOffset),
    .wrData    (segWrData),
    .addrValid (addrValid),
    .physAddr  (physAddr)
  );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [1:0]             reqKind,
  input logic [OFF_W-1:0]       reqOffset,
  input logic                   ovrValid,
  input logic [1:0]             ovrCode,
  input logic                   segWrEn,
  input logic [1:0]             segWrSel,
  input logic [SEG_W-1:0]       segWrData,
  input logic                   addrValid,
  input logic [SEG_W+SHIFT-1:0] physAddr
);

  localparam int ADDR_W = SEG_W + SHIFT;

  // Shadow copy of the segment bases, rebuilt from the write port only.
  logic [SEG_W-1:0]  shadow [4];
  logic [1:0]        pickIdx;
  logic [ADDR_W-1:0] expAddr;
  logic [ADDR_W-1:0] fetchAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) shadow[i] <= '0;
    end else if (segWrEn) begin
      shadow[segWrSel] <= segWrData;
    end
  end

  always_comb begin
    case (reqKind)
      2'd0:    pickIdx = 2'd1;
      2'd3:    pickIdx = 2'd0;
      2'd1:    pickIdx = ovrValid ? ovrCode : 2'd2;
      default: pickIdx = ovrValid ? ovrCode : 2'd3;
    endcase
  end

  assign expAddr   = ADDR_W'({shadow[pickIdx], {SHIFT{1'b0}}}) + ADDR_W'(reqOffset);
  assign fetchAddr = ADDR_W'({shadow[1], {SHIFT{1'b0}}}) + ADDR_W'(reqOffset);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(physAddr));

  p_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> physAddr == $past(expAddr));

  p_fetch_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> physAddr == $past(fetchAddr));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .SHIFT (SHIFT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqKind   (reqKind),
  .reqOffset (reqOffset),
  .ovrValid  (ovrValid),
  .ovrCode   (ovrCode),
  .segWrEn   (segWrEn),
  .segWrSel  (segWrSel),
  .segWrData (segWrData),
  .addrValid (addrValid),
  .physAddr  (physAddr)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [15:0] reqOffset;
  logic        ovrValid;
  logic [1:0]  ovrCode;
  logic        segWrEn;
  logic [1:0]  segWrSel;
  logic [15:0] segWrData;
  logic        addrValid;
  logic [19:0] physAddr;

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .reqOffset (reqOffset),
    .ovrValid  (ovrValid),
    .ovrCode   (ovrCode),
    .segWrEn   (segWrEn),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .addrValid (addrValid),
    .physAddr  (physAddr)
  );

  int          nCmp = 0;
  int          nBad = 0;
  bit          done = 0;
  int          segM [4];
  logic        expValid;
  logic [19:0] expAddr;

  // Reference segment choice: 0 extra, 1 code, 2 stack, 3 data.
  function automatic int pickSeg(input logic [1:0] k, input logic ov, input logic [1:0] oc);
    if (k == 2'd0) return 1;
    if (k == 2'd3) return 0;
    if (ov) return int'(oc);
    return (k == 2'd1) ? 2 : 3;
  endfunction

  task automatic compare(input string tag);
    nCmp++;
    if (addrValid !== expValid || physAddr !== expAddr) begin
      nBad++;
      $display("FAIL %s: valid=%0b addr=%05h expected valid=%0b addr=%05h",
               tag, addrValid, physAddr, expValid, expAddr);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, compare one cycle later.
  task automatic cyc(input logic rv, input logic [1:0] k, input logic [15:0] off,
                     input logic ov, input logic [1:0] oc,
                     input logic we, input logic [1:0] ws, input logic [15:0] wd,
                     input string tag);
    reqValid  = rv;  reqKind  = k;  reqOffset = off;
    ovrValid  = ov;  ovrCode  = oc;
    segWrEn   = we;  segWrSel = ws; segWrData = wd;
    expValid  = rv;
    if (rv) begin
      longint a;
      a = longint'(segM[pickSeg(k, ov, oc)]) * 16 + longint'(off);
      expAddr = 20'(a % 64'h100000);
    end
    if (we) segM[ws] = int'(wd);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) segM[i] = 0;
    expValid = 1'b0;
    expAddr  = '0;
    rstN = 1'b0;
    reqValid = 0; reqKind = 0; reqOffset = 0; ovrValid = 0; ovrCode = 0;
    segWrEn = 0; segWrSel = 0; segWrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R10");              // reset outputs
    rstN = 1'b1;

    cyc(0, 0, 16'h0000, 0, 0, 0, 0, 16'h0000, "R10");
    cyc(1, 0, 16'h0005, 0, 0, 0, 0, 16'h0000, "R10");   // code base is zero
    cyc(1, 2, 16'h0007, 0, 0, 0, 0, 16'h0000, "R10");   // data base is zero
    // Write code segment while fetching from it: old base applies.
    cyc(1, 0, 16'h0011, 0, 0, 1, 1, 16'h1234, "R7");
    cyc(1, 0, 16'h0011, 0, 0, 0, 0, 16'h0000, "R1");    // 12351h
    if (expAddr !== 20'h12351) begin nBad++; $display("FAIL R1: model %05h expected 12351", expAddr); end
    cyc(0, 0, 16'h0000, 0, 0, 1, 2, 16'hFFFF, "R9");
    cyc(0, 0, 16'h0000, 0, 0, 1, 3, 16'hABCD, "R9");
    cyc(0, 3, 16'h9999, 1, 1, 1, 0, 16'h0F00, "R9");
    cyc(1, 1, 16'h0010, 0, 0, 0, 0, 16'h0000, "R2");    // wraps to 00000h
    cyc(1, 1, 16'hFFFF, 0, 0, 0, 0, 16'h0000, "R2");    // 0FFEFh
    cyc(1, 2, 16'h0000, 0, 0, 0, 0, 16'h0000, "R3");    // ABCD0h
    cyc(1, 3, 16'h0001, 0, 0, 0, 0, 16'h0000, "R3");    // 0F001h
    cyc(1, 1, 16'h0002, 0, 0, 0, 0, 16'h0000, "R3");
    cyc(1, 2, 16'h0020, 1, 0, 0, 0, 16'h0000, "R4");    // data via extra
    cyc(1, 1, 16'h0030, 1, 1, 0, 0, 16'h0000, "R4");    // stack via code
    cyc(1, 2, 16'h0040, 1, 2, 0, 0, 16'h0000, "R4");    // data via stack
    cyc(1, 1, 16'h0050, 1, 3, 0, 0, 16'h0000, "R4");    // stack via data
    cyc(1, 0, 16'h0060, 1, 2, 0, 0, 16'h0000, "R5");    // fetch stays code
    cyc(1, 3, 16'h0070, 1, 1, 0, 0, 16'h0000, "R5");    // string dest stays extra
    cyc(1, 2, 16'h0080, 0, 0, 0, 0, 16'h0000, "R6");    // override code ignored
    cyc(1, 1, 16'h0090, 0, 3, 0, 0, 16'h0000, "R6");
    cyc(1, 1, 16'h00A0, 0, 0, 1, 2, 16'h2000, "R7");    // same-cycle stack write
    cyc(1, 1, 16'h00A0, 0, 0, 0, 0, 16'h0000, "R7");    // now sees 2000h
    cyc(0, 1, 16'h1111, 0, 0, 0, 0, 16'h0000, "R8");
    cyc(1, 2, 16'h1111, 0, 0, 0, 0, 16'h0000, "R8");

    for (int n = 0; n < 400; n++) begin
      cyc(1'($urandom), 2'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
          1'(($urandom % 4) == 0), 2'($urandom), 16'($urandom), "R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule